// File: doc/BRIEF.md
# Status-Coded I2C Bus Master

This block is a single-master I2C controller that software paces one bus event at a time. Software writes an address or data byte and sets control bits. The controller then performs one step on the bus: a START, a repeated START, one byte with its acknowledge bit, or a STOP. After each step it posts an 8-bit state code, raises its interrupt flag and holds SCL low until software clears the flag. The firmware driving it is a small state machine keyed on those codes.

Control bits are changed through two write addresses, one that sets bits and one that clears them, so no read-modify-write is needed. SCL high and low times are programmed separately in peripheral clock cycles. Both bus lines are open-drain: the block only produces pull-low enables and reads SDA back, which it also uses to detect lost arbitration.

Top module: `i2c_seq_master`

## Requirements
- R1: After reset the control register reads 0x00, the status reads 0xF8, the interrupt is low and neither line is pulled low.
- R2: Control bits are enable (bit 6), start request (bit 5), stop request (bit 4), event flag (bit 3) and acknowledge enable (bit 2). Writing 1s at address 0 sets those bits and writing 1s at address 3 clears them. Other bits are ignored. Address 0 reads back the register.
- R3: With enable and start request set and the event flag clear, an idle controller produces a START (SDA falls while SCL is high) and then posts code 0x08 with the event flag set.
- R4: While the event flag is set, SCL is held low and the status code does not change.
- R5: The first byte after a START is the data register (address 2) sent MSB first, and bit 0 is the direction (1 = read). In write direction the controller posts 0x18 if the address is ACKed and 0x20 if it is NAKed.
- R6: A data byte written to the bus posts 0x28 on ACK and 0x30 on NAK.
- R7: In read direction an ACKed address posts 0x40. A received byte is placed in the data register. With acknowledge enable set the master drives ACK and posts 0x50; with it clear the master leaves NAK and posts 0x58.
- R8: Start request set while the bus is held, then the flag cleared, produces a repeated START and code 0x10.
- R9: Stop request set, then the flag cleared, produces a STOP (SDA rises while SCL is high). The stop request then clears itself, the status reads 0xF8 and the event flag stays clear.
- R10: If the controller releases SDA during a sent bit but reads it low, it posts 0x38, sets the flag and releases both lines. Clearing the flag returns it to idle with status 0xF8.
- R11: Each SCL high phase lasts the value at address 4 and each low phase lasts the value at address 5, in clock cycles.
- R12: In read direction a NAKed address posts 0x48.
- R13: With enable clear, a start request has no effect: the bus stays released and the status stays 0xF8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from address) |
| irq | output | 1 | Event flag, high while the controller waits for software |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| sda_in | input | 1 | SDA line level read back |

## Verification
The bench builds the block with an 8-bit period counter and a reset period of 5 cycles. It then programs a high time of 4 and a low time of 6, so every bit takes ten cycles and any swap of the two period registers shows up in the measured pulse widths. With bytes this short, a bench slave that counts SCL edges can reach every status code within a few thousand cycles, including the repeated START, both acknowledge choices on reads, and a lost-arbitration bit forced by the slave pulling SDA low.

// File: rtl/i2c_seq_pkg.sv
// Package for the status-coded I2C master: controller states, register
// addresses, control bit positions and posted status codes.
package i2c_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_WAIT, S_BIT_L, S_BIT_H,
        S_RS_L, S_RS_H, S_STOP_L, S_STOP_H, S_STOP_R
    } seq_st_t;

    // register addresses
    localparam logic [2:0] RA_CSET = 3'd0;
    localparam logic [2:0] RA_STAT = 3'd1;
    localparam logic [2:0] RA_DATA = 3'd2;
    localparam logic [2:0] RA_CCLR = 3'd3;
    localparam logic [2:0] RA_SCLH = 3'd4;
    localparam logic [2:0] RA_SCLL = 3'd5;

    // control bit positions
    localparam int CB_EN  = 6;
    localparam int CB_STA = 5;
    localparam int CB_STO = 4;
    localparam int CB_SI  = 3;
    localparam int CB_AA  = 2;
    localparam logic [7:0] CTRL_MASK = 8'h7C;

    // posted status codes
    localparam logic [7:0] SC_START   = 8'h08;
    localparam logic [7:0] SC_RESTART = 8'h10;
    localparam logic [7:0] SC_AW_ACK  = 8'h18;
    localparam logic [7:0] SC_AW_NAK  = 8'h20;
    localparam logic [7:0] SC_DW_ACK  = 8'h28;
    localparam logic [7:0] SC_DW_NAK  = 8'h30;
    localparam logic [7:0] SC_LOST    = 8'h38;
    localparam logic [7:0] SC_AR_ACK  = 8'h40;
    localparam logic [7:0] SC_AR_NAK  = 8'h48;
    localparam logic [7:0] SC_DR_ACK  = 8'h50;
    localparam logic [7:0] SC_DR_NAK  = 8'h58;
    localparam logic [7:0] SC_IDLE    = 8'hF8;

endpackage

// File: rtl/i2c_seq_timer.sv
// Phase timer: loaded with a period when the controller changes state,
// reports expiry once that state has lasted the period (a period of 0
// behaves like 1). Assumes the load pulse comes from a state change.
module i2c_seq_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] period,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // count down from period-1 after each load
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= (period == '0) ? '0 : period - 1'b1;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/i2c_seq_ctrl.sv
// Control register with separate set and clear write ports. Hardware
// sets the event flag and clears the stop request. Assumes the two
// hardware strobes never coincide with software changing the same bit.
module i2c_seq_ctrl
    import i2c_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_we,
    input  logic       clr_we,
    input  logic [7:0] wbits,
    input  logic       hw_si_set,
    input  logic       hw_sto_clr,
    output logic [7:0] ctrl
);
    logic [7:0] ctrl_d;

    // merge software set/clear with hardware updates
    always_comb begin
        ctrl_d = ctrl;
        if (set_we) ctrl_d = ctrl_d | (wbits & CTRL_MASK);
        if (clr_we) ctrl_d = ctrl_d & ~(wbits & CTRL_MASK);
        if (hw_si_set) ctrl_d[CB_SI] = 1'b1;
        if (hw_sto_clr) ctrl_d[CB_STO] = 1'b0;
    end

    // register the control bits
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl <= '0;
        else        ctrl <= ctrl_d;
    end

endmodule

// File: rtl/i2c_seq_master.sv
// Status-coded I2C master. Performs one bus event per software request
// (START, repeated START, one byte plus acknowledge, STOP), then posts a
// status code, raises the event flag and parks SCL low until the flag is
// cleared. Assumes a single master, no slave clock stretching, and that
// software does not set the event flag by hand while a byte is moving.
module i2c_seq_master
    import i2c_seq_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int DEF_PERIOD = 250
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq,
    output logic        scl_oe,
    output logic        sda_oe,
    input  logic        sda_in
);
    localparam logic [CNT_W-1:0] RST_PERIOD = CNT_W'(DEF_PERIOD);

    seq_st_t          st, st_d;
    logic [7:0]       ctrl, shreg, data_q, status_q, byte_code;
    logic [CNT_W-1:0] sclh_q, scll_q, period_d;
    logic [3:0]       bit_idx;
    logic             en, sta, sto, si, aa;
    logic             tmr_exp, hw_si_set, hw_sto_clr;
    logic             addr_phase, rd_mode, bus_held, lost, wait_drv;
    logic             sending, bit_drv, arb_fail;

    assign en  = ctrl[CB_EN];
    assign sta = ctrl[CB_STA];
    assign sto = ctrl[CB_STO];
    assign si  = ctrl[CB_SI];
    assign aa  = ctrl[CB_AA];

    i2c_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_we    (reg_we && reg_addr == RA_CSET),
        .clr_we    (reg_we && reg_addr == RA_CCLR),
        .wbits     (reg_wdata[7:0]),
        .hw_si_set (hw_si_set),
        .hw_sto_clr(hw_sto_clr),
        .ctrl      (ctrl)
    );

    i2c_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (st_d != st),
        .period (period_d),
        .expired(tmr_exp)
    );

    // bit-level decisions: who drives SDA and whether arbitration failed
    always_comb begin
        sending  = addr_phase || !rd_mode;
        bit_drv  = (bit_idx < 4'd8) ? (sending && !shreg[7]) : (!sending && aa);
        arb_fail = (st == S_BIT_H) && tmr_exp && (bit_idx < 4'd8)
                   && sending && shreg[7] && !sda_in;
        case ({addr_phase, rd_mode})
            2'b10:   byte_code = sda_in ? SC_AW_NAK : SC_AW_ACK;
            2'b11:   byte_code = sda_in ? SC_AR_NAK : SC_AR_ACK;
            2'b00:   byte_code = sda_in ? SC_DW_NAK : SC_DW_ACK;
            default: byte_code = sda_in ? SC_DR_NAK : SC_DR_ACK;
        endcase
    end

    // next controller state
    always_comb begin
        st_d = st;
        case (st)
            S_IDLE:   if (en && sta && !si) st_d = S_START;
            S_START:  if (tmr_exp) st_d = S_WAIT;
            S_WAIT: begin
                if (!si) begin
                    if (lost)     st_d = S_IDLE;
                    else if (sto) st_d = S_STOP_L;
                    else if (sta) st_d = S_RS_L;
                    else          st_d = S_BIT_L;
                end
            end
            S_BIT_L:  if (tmr_exp) st_d = S_BIT_H;
            S_BIT_H: begin
                if (tmr_exp)
                    st_d = (arb_fail || bit_idx == 4'd8) ? S_WAIT : S_BIT_L;
            end
            S_RS_L:   if (tmr_exp) st_d = S_RS_H;
            S_RS_H:   if (tmr_exp) st_d = S_START;
            S_STOP_L: if (tmr_exp) st_d = S_STOP_H;
            S_STOP_H: if (tmr_exp) st_d = S_STOP_R;
            S_STOP_R: if (tmr_exp) st_d = S_IDLE;
            default:  st_d = S_IDLE;
        endcase
    end

    // period of the state being entered, and hardware strobes to control
    always_comb begin
        period_d   = (st_d == S_BIT_L || st_d == S_RS_L || st_d == S_STOP_L) ? scll_q : sclh_q;
        hw_si_set  = (st != S_WAIT) && (st_d == S_WAIT);
        hw_sto_clr = (st == S_STOP_R) && (st_d == S_IDLE);
    end

    // state, registers written by software, and byte datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= S_IDLE;
            sclh_q     <= RST_PERIOD;
            scll_q     <= RST_PERIOD;
            data_q     <= '0;
            status_q   <= SC_IDLE;
            shreg      <= '0;
            bit_idx    <= '0;
            addr_phase <= 1'b0;
            rd_mode    <= 1'b0;
            bus_held   <= 1'b0;
            lost       <= 1'b0;
            wait_drv   <= 1'b0;
        end else begin
            st <= st_d;
            if (reg_we && reg_addr == RA_SCLH) sclh_q <= reg_wdata[CNT_W-1:0];
            if (reg_we && reg_addr == RA_SCLL) scll_q <= reg_wdata[CNT_W-1:0];
            if (reg_we && reg_addr == RA_DATA) data_q <= reg_wdata[7:0];
            case (st)
                S_START: if (tmr_exp) begin
                    status_q   <= bus_held ? SC_RESTART : SC_START;
                    bus_held   <= 1'b1;
                    addr_phase <= 1'b1;
                    wait_drv   <= 1'b1;
                end
                S_WAIT: begin
                    if (st_d == S_BIT_L) begin
                        bit_idx <= '0;
                        shreg   <= data_q;
                        if (addr_phase) rd_mode <= data_q[0];
                    end else if (st_d == S_IDLE) begin
                        lost     <= 1'b0;
                        bus_held <= 1'b0;
                        status_q <= SC_IDLE;
                    end
                end
                S_BIT_H: if (tmr_exp) begin
                    if (arb_fail) begin
                        lost     <= 1'b1;
                        status_q <= SC_LOST;
                        wait_drv <= 1'b0;
                    end else if (bit_idx == 4'd8) begin
                        status_q   <= byte_code;
                        addr_phase <= 1'b0;
                        wait_drv   <= 1'b0;
                        if (!sending) data_q <= shreg;
                    end else begin
                        shreg   <= {shreg[6:0], sda_in};
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
                S_STOP_R: if (tmr_exp) begin
                    status_q <= SC_IDLE;
                    bus_held <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // open-drain line enables per state
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        case (st)
            S_START:  sda_oe = 1'b1;
            S_WAIT:   begin scl_oe = !lost; sda_oe = wait_drv && !lost; end
            S_BIT_L:  begin scl_oe = 1'b1; sda_oe = bit_drv; end
            S_BIT_H:  sda_oe = bit_drv;
            S_RS_L:   scl_oe = 1'b1;
            S_STOP_L: begin scl_oe = 1'b1; sda_oe = 1'b1; end
            S_STOP_H: sda_oe = 1'b1;
            default:  ;
        endcase
    end

    // register read mux
    always_comb begin
        case (reg_addr)
            RA_CSET: reg_rdata = {8'h00, ctrl};
            RA_STAT: reg_rdata = {8'h00, status_q};
            RA_DATA: reg_rdata = {8'h00, data_q};
            RA_SCLH: reg_rdata = 16'(sclh_q);
            RA_SCLL: reg_rdata = 16'(scll_q);
            default: reg_rdata = '0;
        endcase
    end

    assign irq = si;

    // R3: leaving the START phase posts a start code
    assert_start_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == S_START && st == S_WAIT) |-> (si && (status_q == SC_START || status_q == SC_RESTART)));

    // R4: status frozen while the flag stays set
    assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (si && $past(si)) |-> $stable(status_q));

    // R9: STOP completion clears the request and reports idle
    assert_stop_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == S_STOP_R && st == S_IDLE) |-> (!sto && !si && status_q == SC_IDLE));

    // R10: lost arbitration leaves both lines released
    assert_lost_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (si && status_q == SC_LOST) |-> (!scl_oe && !sda_oe));

    // R13: disabled controller never leaves idle
    assert_disabled_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && !en) |=> (st == S_IDLE));

endmodule

// File: tb/test_i2c_seq_master.sv
// Directed bench: a small edge-counting slave answers on the bus, each
// task runs one scenario and checks its own results.
module test_i2c_seq_master;
    import i2c_seq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    wire  [15:0] reg_rdata;
    wire         irq, scl_oe, sda_oe;
    logic        sda_in;

    int n_chk = 0;
    int n_fail = 0;

    // bench slave state
    logic [8:0] slv_pat = 9'h1FF;
    int         bitcnt = -1;
    logic       pull;
    logic       p_scl = 1'b1, p_sda = 1'b1;
    logic [8:0] cap = 9'd0;
    int start_cnt = 0, stop_cnt = 0;
    int hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0;
    wire scl_l = ~scl_oe;

    always #4 clk = ~clk;

    i2c_seq_master #(.CNT_W(8), .DEF_PERIOD(5)) i_i2c_seq_master (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
    );

    always_comb pull = (bitcnt >= 0 && bitcnt <= 8) ? !slv_pat[8 - bitcnt] : 1'b0;
    always_comb sda_in = ~sda_oe & ~pull;

    // slave: START/STOP detection, bit counting, capture and SCL pulse widths
    always @(posedge clk) begin
        p_scl <= scl_l;
        p_sda <= sda_in;
        if (p_scl && scl_l && p_sda && !sda_in) begin
            bitcnt <= -1; start_cnt <= start_cnt + 1;
        end else if (p_scl && scl_l && !p_sda && sda_in) begin
            bitcnt <= -1; stop_cnt <= stop_cnt + 1;
        end else if (p_scl && !scl_l) begin
            bitcnt <= (bitcnt >= 8) ? 0 : bitcnt + 1;
        end
        if (!p_scl && scl_l) cap <= {cap[7:0], sda_in};
        if (scl_l == p_scl) begin
            if (scl_l) hi_run <= hi_run + 1; else lo_run <= lo_run + 1;
        end else if (scl_l) begin
            last_lo <= lo_run; hi_run <= 1;
        end else begin
            last_hi <= hi_run; lo_run <= 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (!irq && n < 3000) begin @(negedge clk); n++; end
        chk({req, " event flag raised"}, irq, 1);
    endtask

    task automatic wait_idle(input string req);
        logic [15:0] v;
        int n = 0;
        rd(RA_STAT, v);
        while (v[7:0] != SC_IDLE && n < 3000) begin @(negedge clk); rd(RA_STAT, v); n++; end
        chk({req, " idle code"}, v, SC_IDLE);
    endtask

    task automatic exp_status(input string req, input logic [7:0] code);
        logic [15:0] v;
        rd(RA_STAT, v);
        chk(req, v, code);
    endtask

    // START plus first-code check, shared by the transfer scenarios
    task automatic open_bus(input logic [7:0] abyte);
        wr(RA_DATA, {8'h00, abyte});
        wr(RA_CSET, 16'h0060);
        wait_irq("R3");
        exp_status("R3 start code", SC_START);
    endtask

    // release the flag with the slave set to answer with pat
    task automatic step(input logic [8:0] pat, input logic [7:0] clrbits);
        slv_pat = pat;
        wr(RA_CCLR, {8'h00, clrbits});
        wait_irq("step");
    endtask

    task automatic close_bus(input string req);
        logic [15:0] v;
        int s0 = stop_cnt;
        slv_pat = 9'h1FF;
        wr(RA_CSET, 16'h0010);
        wr(RA_CCLR, 16'h0008);
        wait_idle(req);
        repeat (2) @(negedge clk);
        chk({req, " STOP seen on bus"}, stop_cnt, s0 + 1);
        rd(RA_CSET, v);
        chk({req, " stop request self-cleared, flag clear"}, v & 16'h0018, 0);
        chk({req, " irq low"}, irq, 0);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(RA_CSET, v); chk("R1 ctrl", v, 0);
        rd(RA_STAT, v); chk("R1 status", v, SC_IDLE);
        chk("R1 irq", irq, 0);
        chk("R1 scl_oe", scl_oe, 0);
        chk("R1 sda_oe", sda_oe, 0);
    endtask

    task automatic t_ctrl;
        logic [15:0] v;
        wr(RA_CSET, 16'h007C); rd(RA_CSET, v); chk("R2 set all", v, 16'h007C);
        wr(RA_CCLR, 16'h0024); rd(RA_CSET, v); chk("R2 clear some", v, 16'h0058);
        wr(RA_CCLR, 16'h00FF); rd(RA_CSET, v); chk("R2 clear all", v, 16'h0000);
        wr(RA_CSET, 16'h0083); rd(RA_CSET, v); chk("R2 unused bits", v, 16'h0000);
        chk("R2 bus untouched", scl_oe | sda_oe, 0);
    endtask

    task automatic t_disabled;
        logic [15:0] v;
        int s0 = start_cnt;
        wr(RA_CSET, 16'h0020);
        repeat (60) @(negedge clk);
        chk("R13 scl released", scl_oe, 0);
        chk("R13 sda released", sda_oe, 0);
        chk("R13 no START", start_cnt, s0);
        rd(RA_STAT, v); chk("R13 status idle", v, SC_IDLE);
        wr(RA_CCLR, 16'h0020);
    endtask

    task automatic t_timing;
        logic [15:0] v;
        wr(RA_SCLH, 16'd4);
        wr(RA_SCLL, 16'd6);
        rd(RA_SCLH, v); chk("R11 high period readback", v, 4);
        rd(RA_SCLL, v); chk("R11 low period readback", v, 6);
    endtask

    task automatic t_write;
        logic [15:0] v;
        int s0 = start_cnt;
        open_bus(8'hA4);
        chk("R3 START on bus", start_cnt, s0 + 1);
        repeat (25) @(negedge clk);
        chk("R4 scl held low", scl_oe, 1);
        exp_status("R4 status frozen", SC_START);
        step(9'h1FE, 8'h28);
        exp_status("R5 address ACK", SC_AW_ACK);
        chk("R5 address bits on bus", cap[8:1], 8'hA4);
        chk("R11 high width", last_hi, 4);
        chk("R11 low width", last_lo, 6);
        wr(RA_DATA, 16'h003C);
        step(9'h1FE, 8'h08);
        exp_status("R6 data ACK", SC_DW_ACK);
        chk("R6 data bits on bus", cap[8:1], 8'h3C);
        wr(RA_DATA, 16'h005A);
        step(9'h1FF, 8'h08);
        exp_status("R6 data NAK", SC_DW_NAK);
        chk("R6 NAK data bits", cap[8:1], 8'h5A);
        close_bus("R9");
    endtask

    task automatic t_addr_nak;
        open_bus(8'hB0);
        step(9'h1FF, 8'h28);
        exp_status("R5 address NAK", SC_AW_NAK);
        close_bus("R9 after NAK");
    endtask

    task automatic t_read;
        logic [15:0] v;
        int s0;
        open_bus(8'hA4);
        step(9'h1FE, 8'h28);
        exp_status("R5 address ACK before restart", SC_AW_ACK);
        s0 = start_cnt;
        wr(RA_CSET, 16'h0020);
        step(9'h1FF, 8'h08);
        exp_status("R8 repeated start code", SC_RESTART);
        chk("R8 repeated START on bus", start_cnt, s0 + 1);
        wr(RA_DATA, 16'h00A5);
        step(9'h1FE, 8'h28);
        exp_status("R7 read address ACK", SC_AR_ACK);
        wr(RA_CSET, 16'h0004);
        step({8'hC3, 1'b1}, 8'h08);
        exp_status("R7 byte with ACK", SC_DR_ACK);
        rd(RA_DATA, v); chk("R7 received byte", v, 16'h00C3);
        chk("R7 master drove ACK", cap[0], 0);
        step({8'h7E, 1'b1}, 8'h0C);
        exp_status("R7 byte with NAK", SC_DR_NAK);
        rd(RA_DATA, v); chk("R7 last received byte", v, 16'h007E);
        chk("R7 master left NAK", cap[0], 1);
        close_bus("R9 after read");
    endtask

    task automatic t_read_nak;
        open_bus(8'hA5);
        step(9'h1FF, 8'h28);
        exp_status("R12 read address NAK", SC_AR_NAK);
        close_bus("R9 after read NAK");
    endtask

    task automatic t_arb;
        logic [15:0] v;
        open_bus(8'hA0);
        step(9'h0FF, 8'h28);
        exp_status("R10 lost code", SC_LOST);
        chk("R10 scl released", scl_oe, 0);
        chk("R10 sda released", sda_oe, 0);
        slv_pat = 9'h1FF;
        wr(RA_CCLR, 16'h0028);
        wait_idle("R10");
        repeat (10) @(negedge clk);
        chk("R10 irq low after return", irq, 0);
        rd(RA_STAT, v); chk("R10 stays idle", v, SC_IDLE);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_ctrl;
        t_disabled;
        t_timing;
        t_write;
        t_addr_nak;
        t_read;
        t_read_nak;
        t_arb;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule